// File: doc/BRIEF.md
# Priority Shared-Memory Bank Controller

This controller fronts a small set of on-chip RAM banks that are shared by hardware kernels and by a processor bus slave. Each bank has either one or two access ports. The kernels address a bank directly by bank index and local offset. The processor sees every bank laid end to end in a single flat address window. The controller decodes a flat address into a bank and an offset, and arbitrates the ports of every bank each cycle. It also drives the ready signal the bus uses to stall the processor.

Kernel requests always win. The kernels' schedules are built so that they never ask one bank for more ports than it has. The processor uses a bank only through a port that the kernels leave idle in that same cycle, and it never displaces a kernel. A held processor request is registered inside the block. It is retried every cycle and keeps ready low until it is granted.

Top module: `bank_port_ctl`

## Requirements
- R1: After reset, cpu_ready_o is 0 and cpu_rdata_o is 0.
- R2: The flat window maps bank 0 to addresses 0..15, bank 1 to 16..47 and bank 2 to 48..95. The local offset is the flat address minus the bank's first address, so a word a kernel writes at (bank, offset) is the word the processor reads at that flat address.
- R3: Each kernel port with k_valid_i set reads or writes its word in that cycle, with no stall. Read data appears on k_rdata_o one cycle later. A kernel reading and a write to the same word in the same cycle return the old value.
- R4: Bank 0 has one port, and banks 1 and 2 have two. A pending processor access is granted in a cycle only if the kernel requests to its bank in that cycle leave a port unused.
- R5: While a processor request is held, cpu_ready_o stays 0. The request is retried every cycle and is granted in the first cycle that offers a spare port.
- R6: A request is captured at an edge where cpu_req_i is 1 and the block is idle, and it is first tried in the next cycle. cpu_ready_o pulses for exactly one cycle, in the cycle after the grant. For a read, cpu_rdata_o then carries the word as it was before that grant cycle's writes.
- R7: If a processor write and a kernel write hit the same word in the same cycle, the kernel's data is stored. The processor still receives its ready pulse.
- R8: A flat address of 96 or above is granted in its first try cycle. A read returns 0, and a write changes no word.
- R9: Changes on cpu_addr_i, cpu_we_i and cpu_wdata_i after capture do not affect the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| k_valid_i | input | NUM_KP | Kernel port request valid |
| k_bank_i | input | NUM_KP x BANK_W | Kernel target bank index |
| k_off_i | input | NUM_KP x OFF_W | Kernel offset inside the bank |
| k_we_i | input | NUM_KP | Kernel write enable (1 = write) |
| k_wdata_i | input | NUM_KP x DATA_W | Kernel write data |
| k_rdata_o | output | NUM_KP x DATA_W | Kernel read data, one cycle after the request |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | Processor write enable (1 = write) |
| cpu_addr_i | input | ADDR_W | Processor flat word address |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Processor read data, valid with cpu_ready_o |

## Verification
On every cycle, the assertions check several properties: kernel demand never exceeds a bank's port count, and a processor grant always takes a port beyond those the kernels hold. They also check that ready stays low during a hold, follows a grant by exactly one cycle and never lasts two cycles, and that the held address and data do not move. Only the bench's scenarios can show the rest. These are correct data through the flat-to-bank mapping at every bank boundary, the kernel winning a same-word write race, and out-of-window accesses that leave memory untouched. They also cover addresses scrambled during a hold that have no effect, and hold lengths that match the kernels' saturation patterns.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int NUM_BANKS = 3;
  localparam int DATA_W    = 16;
  localparam int NUM_KP    = 2;
  localparam int ADDR_W    = 7;
  localparam int OFF_W     = 6;
  localparam int MAX_PORTS = 2;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  function automatic int bank_depth(input int b);
    return 16 * (b + 1);
  endfunction

  function automatic int bank_base(input int b);
    int s;
    s = 0;
    for (int i = 0; i < b; i++) s += bank_depth(i);
    return s;
  endfunction

  function automatic int bank_nports(input int b);
    return (b == 0) ? 1 : 2;
  endfunction

  localparam int WINDOW = bank_base(NUM_BANKS);
endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
  import bpc_pkg::*;
#(
  parameter int N_BANKS = NUM_BANKS,
  parameter int A_W     = ADDR_W,
  parameter int O_W     = OFF_W,
  parameter int B_W     = BANK_W
) (
  input  logic [A_W-1:0] addr_i,
  output logic           hit_o,
  output logic [B_W-1:0] bank_o,
  output logic [O_W-1:0] off_o
);
  always_comb begin
    hit_o  = 1'b0;
    bank_o = '0;
    off_o  = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (int'(addr_i) >= bank_base(b) && int'(addr_i) < bank_base(b) + bank_depth(b)) begin
        hit_o  = 1'b1;
        bank_o = B_W'(b);
        off_o  = O_W'(int'(addr_i) - bank_base(b));
      end
    end
  end
endmodule

// File: rtl/bpc_arb.sv
module bpc_arb
  import bpc_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int NPORTS  = 1,
  parameter int N_K     = NUM_KP,
  parameter int B_W     = BANK_W,
  parameter int O_W     = OFF_W,
  parameter int D_W     = DATA_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_K-1:0]                    k_valid_i,
  input  logic [N_K-1:0][B_W-1:0]           k_bank_i,
  input  logic [N_K-1:0][O_W-1:0]           k_off_i,
  input  logic [N_K-1:0]                    k_we_i,
  input  logic [N_K-1:0][D_W-1:0]           k_wd_i,
  input  logic                              cpu_try_i,
  input  logic [B_W-1:0]                    cpu_bank_i,
  input  logic [O_W-1:0]                    cpu_off_i,
  input  logic                              cpu_we_i,
  input  logic [D_W-1:0]                    cpu_wd_i,
  output logic [MAX_PORTS-1:0]              p_en_o,
  output logic [MAX_PORTS-1:0]              p_we_o,
  output logic [MAX_PORTS-1:0][O_W-1:0]     p_off_o,
  output logic [MAX_PORTS-1:0][D_W-1:0]     p_wd_o,
  output logic [N_K-1:0]                    k_slot_o,
  output logic                              cpu_gnt_o,
  output logic                              cpu_slot_o
);
  int kern_cnt;

  // kernels fill ports from index 0 upward; cpu takes the next free one
  always_comb begin
    p_en_o     = '0;
    p_we_o     = '0;
    p_off_o    = '0;
    p_wd_o     = '0;
    k_slot_o   = '0;
    cpu_gnt_o  = 1'b0;
    cpu_slot_o = 1'b0;
    kern_cnt   = 0;
    for (int k = 0; k < N_K; k++) begin
      if (k_valid_i[k] && k_bank_i[k] == B_W'(BANK_ID)) begin
        if (kern_cnt < NPORTS) begin
          p_en_o[kern_cnt]  = 1'b1;
          p_we_o[kern_cnt]  = k_we_i[k];
          p_off_o[kern_cnt] = k_off_i[k];
          p_wd_o[kern_cnt]  = k_wd_i[k];
        end
        k_slot_o[k] = 1'(kern_cnt);
        kern_cnt++;
      end
    end
    if (cpu_try_i && cpu_bank_i == B_W'(BANK_ID) && kern_cnt < NPORTS) begin
      cpu_gnt_o         = 1'b1;
      cpu_slot_o        = 1'(kern_cnt);
      p_en_o[kern_cnt]  = 1'b1;
      p_we_o[kern_cnt]  = cpu_we_i;
      p_off_o[kern_cnt] = cpu_off_i;
      p_wd_o[kern_cnt]  = cpu_wd_i;
    end
  end

  AST_KERNEL_PORTS_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kern_cnt <= NPORTS); // R3

  AST_CPU_SPARE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o |-> ($countones(p_en_o) == kern_cnt + 1)); // R4
endmodule

// File: rtl/bpc_ram.sv
module bpc_ram
  import bpc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 1,
  parameter int O_W    = OFF_W,
  parameter int D_W    = DATA_W
) (
  input  logic                          clk_i,
  input  logic [MAX_PORTS-1:0]          en_i,
  input  logic [MAX_PORTS-1:0]          we_i,
  input  logic [MAX_PORTS-1:0][O_W-1:0] off_i,
  input  logic [MAX_PORTS-1:0][D_W-1:0] wd_i,
  output logic [MAX_PORTS-1:0][D_W-1:0] rd_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [D_W-1:0] mem [DEPTH];
  logic [MAX_PORTS-1:0][D_W-1:0] rd_q;

  // descending order: port 0 (kernel side) is applied last and wins
  always_ff @(posedge clk_i) begin
    for (int p = MAX_PORTS - 1; p >= 0; p--) begin
      if (p < NPORTS && en_i[p] && int'(off_i[p]) < DEPTH) begin
        if (we_i[p]) mem[off_i[p][IW-1:0]] <= wd_i[p];
        else         rd_q[p] <= mem[off_i[p][IW-1:0]];
      end
    end
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/bank_port_ctl.sv
module bank_port_ctl
  import bpc_pkg::*;
#(
  parameter int N_BANKS = NUM_BANKS,
  parameter int N_K     = NUM_KP,
  parameter int A_W     = ADDR_W,
  parameter int O_W     = OFF_W,
  parameter int D_W     = DATA_W,
  parameter int B_W     = BANK_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_K-1:0]          k_valid_i,
  input  logic [N_K-1:0][B_W-1:0] k_bank_i,
  input  logic [N_K-1:0][O_W-1:0] k_off_i,
  input  logic [N_K-1:0]          k_we_i,
  input  logic [N_K-1:0][D_W-1:0] k_wdata_i,
  output logic [N_K-1:0][D_W-1:0] k_rdata_o,
  input  logic                    cpu_req_i,
  input  logic                    cpu_we_i,
  input  logic [A_W-1:0]          cpu_addr_i,
  input  logic [D_W-1:0]          cpu_wdata_i,
  output logic                    cpu_ready_o,
  output logic [D_W-1:0]          cpu_rdata_o
);
  logic           pend_q, resp_q, h_we_q;
  logic [A_W-1:0] h_addr_q;
  logic [D_W-1:0] h_wd_q;
  logic           r_miss_q, r_read_q, r_slot_q;
  logic [B_W-1:0] r_bank_q;
  logic [N_K-1:0][B_W-1:0] kr_bank_q;
  logic [N_K-1:0]          kr_slot_q;

  logic           dec_hit;
  logic [B_W-1:0] dec_bank;
  logic [O_W-1:0] dec_off;

  logic [N_BANKS-1:0][MAX_PORTS-1:0]          p_en, p_we;
  logic [N_BANKS-1:0][MAX_PORTS-1:0][O_W-1:0] p_off;
  logic [N_BANKS-1:0][MAX_PORTS-1:0][D_W-1:0] p_wd, p_rd;
  logic [N_BANKS-1:0][N_K-1:0]                k_slot;
  logic [N_BANKS-1:0]                         b_gnt, b_slot;

  logic cpu_try, cpu_gnt, slot_sel;

  bpc_decode #(.N_BANKS(N_BANKS), .A_W(A_W), .O_W(O_W), .B_W(B_W)) u_dec (
    .addr_i(h_addr_q), .hit_o(dec_hit), .bank_o(dec_bank), .off_o(dec_off)
  );

  assign cpu_try = pend_q && dec_hit;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    bpc_arb #(
      .BANK_ID(b), .NPORTS(bank_nports(b)), .N_K(N_K),
      .B_W(B_W), .O_W(O_W), .D_W(D_W)
    ) u_arb (
      .clk_i, .rst_ni,
      .k_valid_i, .k_bank_i, .k_off_i, .k_we_i, .k_wd_i(k_wdata_i),
      .cpu_try_i(cpu_try), .cpu_bank_i(dec_bank), .cpu_off_i(dec_off),
      .cpu_we_i(h_we_q), .cpu_wd_i(h_wd_q),
      .p_en_o(p_en[b]), .p_we_o(p_we[b]), .p_off_o(p_off[b]), .p_wd_o(p_wd[b]),
      .k_slot_o(k_slot[b]), .cpu_gnt_o(b_gnt[b]), .cpu_slot_o(b_slot[b])
    );

    bpc_ram #(
      .DEPTH(bank_depth(b)), .NPORTS(bank_nports(b)), .O_W(O_W), .D_W(D_W)
    ) u_ram (
      .clk_i, .en_i(p_en[b]), .we_i(p_we[b]), .off_i(p_off[b]),
      .wd_i(p_wd[b]), .rd_o(p_rd[b])
    );
  end

  // out-of-window access completes without touching a bank
  assign cpu_gnt  = pend_q && (!dec_hit || (|b_gnt));
  assign slot_sel = b_slot[dec_bank];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      resp_q   <= 1'b0;
      h_we_q   <= 1'b0;
      h_addr_q <= '0;
      h_wd_q   <= '0;
      r_miss_q <= 1'b0;
      r_read_q <= 1'b0;
      r_slot_q <= 1'b0;
      r_bank_q <= '0;
    end else if (pend_q) begin
      if (cpu_gnt) begin
        pend_q   <= 1'b0;
        resp_q   <= 1'b1;
        r_miss_q <= !dec_hit;
        r_read_q <= !h_we_q;
        r_slot_q <= slot_sel;
        r_bank_q <= dec_bank;
      end
    end else if (resp_q) begin
      resp_q <= 1'b0;
    end else if (cpu_req_i) begin
      pend_q   <= 1'b1;
      h_we_q   <= cpu_we_i;
      h_addr_q <= cpu_addr_i;
      h_wd_q   <= cpu_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kr_bank_q <= '0;
      kr_slot_q <= '0;
    end else begin
      for (int k = 0; k < N_K; k++) begin
        kr_bank_q[k] <= k_bank_i[k];
        kr_slot_q[k] <= k_slot[k_bank_i[k]][k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_K; k++) k_rdata_o[k] = p_rd[kr_bank_q[k]][kr_slot_q[k]];
  end

  assign cpu_ready_o = resp_q;
  assign cpu_rdata_o = (resp_q && r_read_q && !r_miss_q) ? p_rd[r_bank_q][r_slot_q] : '0;

  AST_HELD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cpu_gnt) |=> !cpu_ready_o); // R5

  AST_READY_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cpu_gnt) |=> cpu_ready_o); // R6

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cpu_gnt) |=> ($stable(h_addr_q) && $stable(h_wd_q) && $stable(h_we_q))); // R9
endmodule

// File: tb/tb_bank_port_ctl.sv
`timescale 1ns/1ps
module tb_bank_port_ctl;
  import bpc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NUM_KP-1:0]             kv = '0;
  logic [NUM_KP-1:0][BANK_W-1:0] kb = '0;
  logic [NUM_KP-1:0][OFF_W-1:0]  ko = '0;
  logic [NUM_KP-1:0]             kw = '0;
  logic [NUM_KP-1:0][DATA_W-1:0] kd = '0;
  logic [NUM_KP-1:0][DATA_W-1:0] krd;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wd = '0;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rd;

  bank_port_ctl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .k_valid_i(kv), .k_bank_i(kb), .k_off_i(ko), .k_we_i(kw), .k_wdata_i(kd),
    .k_rdata_o(krd),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wd), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rd)
  );

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  logic [DATA_W-1:0] mem [WINDOW];
  bit m_pend = 0, m_resp = 0, m_we = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [DATA_W-1:0] m_wd = '0, m_exp = '0;
  bit [NUM_KP-1:0] ekv = '0;
  logic [DATA_W-1:0] ekd [NUM_KP];

  function automatic int bank_of(input int a);
    for (int b = 0; b < NUM_BANKS; b++)
      if (a >= bank_base(b) && a < bank_base(b) + bank_depth(b)) return b;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int kc [NUM_BANKS];
    bit nr, gw;
    int b, fa;
    for (int i = 0; i < NUM_BANKS; i++) kc[i] = 0;
    for (int k = 0; k < NUM_KP; k++) if (kv[k]) kc[kb[k]]++;
    for (int k = 0; k < NUM_KP; k++) begin
      ekv[k] = kv[k] && !kw[k];
      ekd[k] = kv[k] ? mem[bank_base(int'(kb[k])) + int'(ko[k])] : '0;
    end
    nr = 0; gw = 0;
    if (m_pend) begin
      b = bank_of(int'(m_addr));
      if (b < 0 || kc[b] < bank_nports(b)) begin
        m_pend = 0; nr = 1;
        m_exp = (b < 0 || m_we) ? '0 : mem[m_addr];
        gw = (b >= 0) && m_we;
      end
    end else if (m_resp) begin
      nr = 0;
    end else if (cpu_req) begin
      m_pend = 1; m_we = cpu_we; m_addr = cpu_addr; m_wd = cpu_wd;
    end
    if (gw) mem[m_addr] = m_wd;
    for (int k = 0; k < NUM_KP; k++)
      if (kv[k] && kw[k]) begin
        fa = bank_base(int'(kb[k])) + int'(ko[k]);
        mem[fa] = kd[k];
      end
    m_resp = nr;
    @(posedge clk);
    @(negedge clk);
    chk({cur_tag, " R4 R5 R6 ready"}, 32'(cpu_ready), 32'(m_resp));
    if (m_resp && !m_we) chk({cur_tag, " R2 R6 rdata"}, 32'(cpu_rd), 32'(m_exp));
    for (int k = 0; k < NUM_KP; k++)
      if (ekv[k]) chk("R3 kernel rdata", 32'(krd[k]), 32'(ekd[k]));
    if (cpu_req && cpu_ready) cpu_req = 1'b0;
    else if (cpu_req && m_pend) begin
      cpu_addr = ADDR_W'($urandom);
      cpu_wd   = DATA_W'($urandom);
      cpu_we   = 1'($urandom);
    end
  endtask

  task automatic k_idle();
    kv = '0; kw = '0;
  endtask

  task automatic k_put(input int k, input int b, input int o, input bit w, input int d);
    kv[k] = 1'b1; kb[k] = BANK_W'(b); ko[k] = OFF_W'(o); kw[k] = w; kd[k] = DATA_W'(d);
  endtask

  task automatic k_fill(input int b);
    k_idle();
    k_put(0, b, 0, 0, 0);
    if (bank_nports(b) > 1) k_put(1, b, 1, 0, 0);
  endtask

  task automatic k_rand();
    k_idle();
    for (int k = 0; k < NUM_KP; k++)
      if ($urandom_range(9) < 6) begin
        int b;
        b = $urandom_range(NUM_BANKS - 1);
        k_put(k, b, $urandom_range(bank_depth(b) - 1), 1'($urandom), $urandom);
      end
    if (kv[0] && kv[1] && kb[0] == kb[1]) begin
      if (bank_nports(int'(kb[0])) == 1) kv[1] = 1'b0;
      else if (ko[0] == ko[1] && (kw[0] || kw[1])) kv[1] = 1'b0;
    end
  endtask

  // mode: 0 idle, 1 fill bank bb, 2 one kernel read on bb, 3 kernel write to the cpu word
  task automatic cpu_op(input bit we, input int addr, input int data,
                        input int mode, input int bb, input int n);
    int c;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wd = DATA_W'(data);
    c = 0;
    while (cpu_req) begin
      if (c >= n || mode == 0) k_idle();
      else if (mode == 1) k_fill(bb);
      else if (mode == 2) begin k_idle(); k_put(0, bb, 2, 0, 0); end
      else begin
        int b2;
        b2 = bank_of(addr);
        k_idle(); k_put(0, b2, addr - bank_base(b2), 1, data ^ 16'h5a5a);
      end
      step();
      c++;
    end
    k_idle();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WINDOW; i++) mem[i] = '0;
    for (int k = 0; k < NUM_KP; k++) ekd[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_ready), 32'd0);
    chk("R1 rdata after reset", 32'(cpu_rd), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: preload every word through a kernel port
    cur_tag = "R3";
    for (int f = 0; f < WINDOW; f++) begin
      int b;
      b = bank_of(f);
      k_idle();
      k_put(0, b, f - bank_base(b), 1, f * 37 + 5);
      step();
    end
    for (int f = 0; f < WINDOW; f += 7) begin
      int b;
      b = bank_of(f);
      k_idle();
      k_put(1, b, f - bank_base(b), 0, 0);
      step();
    end
    k_idle();
    step();

    // R2: bank boundaries through the flat window
    cur_tag = "R2";
    cpu_op(0, 0, 0, 0, 0, 0);
    cpu_op(0, 15, 0, 0, 0, 0);
    cpu_op(0, 16, 0, 0, 0, 0);
    cpu_op(0, 47, 0, 0, 0, 0);
    cpu_op(0, 48, 0, 0, 0, 0);
    cpu_op(0, 95, 0, 0, 0, 0);

    // R4 R5 R9: holds while kernels saturate a bank, inputs scrambled meanwhile
    cur_tag = "R4 R5 R9";
    cpu_op(0, 20, 0, 1, 1, 5);
    cpu_op(0, 3, 0, 1, 0, 4);
    cpu_op(1, 10, 16'h1234, 1, 0, 3);
    cpu_op(0, 10, 0, 1, 1, 3);
    cpu_op(0, 60, 0, 2, 2, 4);
    cpu_op(0, 5, 0, 1, 2, 4);

    // R6: write then read back
    cur_tag = "R6";
    cpu_op(1, 30, 16'hc0de, 0, 0, 0);
    cpu_op(0, 30, 0, 0, 0, 0);

    // R7: same word written by kernel and cpu in the grant cycle
    cur_tag = "R7";
    cpu_op(1, 33, 16'h7777, 3, 0, 4);
    cpu_op(0, 33, 0, 0, 0, 0);
    cpu_op(1, 70, 16'h0f0f, 3, 0, 4);
    cpu_op(0, 70, 0, 0, 0, 0);

    // R8: addresses outside the window
    cur_tag = "R8";
    cpu_op(0, 100, 0, 1, 1, 3);
    cpu_op(1, 96, 16'hdead, 0, 0, 0);
    cpu_op(1, 127, 16'hbeef, 0, 0, 0);
    cpu_op(0, 127, 0, 0, 0, 0);
    cpu_op(0, 0, 0, 0, 0, 0);
    cpu_op(0, 95, 0, 0, 0, 0);

    // mixed random traffic
    cur_tag = "R2 R3 R7 R8 R9";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(3) == 0) k_fill($urandom_range(NUM_BANKS - 1));
      else k_rand();
      if (!cpu_req && !m_pend && !m_resp && $urandom_range(9) < 4) begin
        cpu_req  = 1'b1;
        cpu_we   = 1'($urandom);
        cpu_addr = ADDR_W'($urandom_range(103));
        cpu_wd   = DATA_W'($urandom);
      end
      step();
    end
    k_idle();
    while (cpu_req || m_pend || m_resp) step();
    for (int f = 0; f < WINDOW; f += 5) cpu_op(0, f, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule